// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block evaluates a three-tap finite impulse response filter three samples at a time. Each clock it takes a block of three consecutive input samples on three lanes, the earliest one on lane 0, and returns the three matching filter outputs in the same clock. The sample rate is therefore three times the clock rate. The logic between registers stays at one multiply followed by the adds of a single tap sum.

The only state is a pair of history registers. They hold the two newest samples of the last accepted block. Because one register step spans a whole block, each such register delays by three sample periods. Lane outputs combine samples of the current block with these two held samples. The three tap weights come in on a coefficient bus. A single valid flag qualifies each input block and is reflected on the output. The serial-to-parallel and parallel-to-serial conversions are left to the surrounding logic.

Top module: `blk3_fir`

## Requirements
- R1: Lane 0 output equals w0·s(3k) + w1·s(3k-1) + w2·s(3k-2), where s(3k) is input lane 0 of the current clock. Coefficient w0 sits in coef_blk bits [15:0], w1 in [31:16] and w2 in [47:32]. The result appears in the same clock as the inputs.
- R2: Lane 1 output equals w0·s(3k+1) + w1·s(3k) + w2·s(3k-1), in the same clock as the inputs.
- R3: Lane 2 output equals w0·s(3k+2) + w1·s(3k+1) + w2·s(3k), in the same clock as the inputs.
- R4: s(3k-1) and s(3k-2) are the lane 2 and lane 1 samples of the most recent earlier clock in which in_vld was high. A single sample therefore reaches all three tap positions across two consecutive blocks.
- R5: A clock edge with rst high clears both held samples to zero. Samples before the first accepted block, or before the first block after a reset, count as zero.
- R6: out_vld equals in_vld in every clock, including while rst is high.
- R7: A block presented with in_vld low does not change the held samples. The next valid block's outputs use the samples of the last valid block.
- R8: Samples and weights are 16-bit two's complement. Lane results are 34-bit two's complement and exact for all operands, including all operands at -32768. Input lane i occupies in_blk bits [16i+15:16i], and output lane i occupies out_blk bits [34i+33:34i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the held samples |
| in_vld | input | 1 | Input block qualifier |
| in_blk | input | 48 | Three signed samples, lane 0 (earliest) in the low bits |
| coef_blk | input | 48 | Three signed tap weights, w0 in the low bits |
| out_vld | output | 1 | Output block qualifier |
| out_blk | output | 102 | Three signed 34-bit results, lane 0 in the low bits |

## Verification
The bench feeds several stimulus patterns, and each one isolates a different fault:
- A single impulse on lane 0 followed by zero blocks places each weight on a known lane and clock. A swapped tap or a wrong history slot shows up at once.
- A ramp makes every sample distinct, so using the wrong held sample changes the sum.
- Blocks of full-scale negative values expose truncation or lost sign extension in the 34-bit results.
- Blocks with in_vld low carry garbage data and are followed by valid blocks, to show that the history is held.
- A reset in mid-stream is followed by zero input, which exposes any uncleared history.
- Long pseudo-random streams, with valid gaps mixed in, are checked against a serial single-rate filter lane by lane.

// File: rtl/blk3_fir_pkg.sv
package blk3_fir_pkg;

  localparam int unsigned DEF_SAMPLE_W = 16;
  localparam int unsigned DEF_COEF_W   = 16;
  localparam int unsigned DEF_LANES    = 3;
  localparam int unsigned DEF_TAPS     = 3;

  // exact width of a sum of taps products
  function automatic int unsigned acc_width(int unsigned sw, int unsigned cw, int unsigned taps);
    return sw + cw + $clog2(taps);
  endfunction

endpackage

// File: rtl/blk3_fir_hist.sv
// Block-delay registers: keep the newest DEPTH samples of the last valid block.
module blk3_fir_hist #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned DEPTH    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [DEPTH*SAMPLE_W-1:0]    d,
  output logic [DEPTH*SAMPLE_W-1:0]    q
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [SAMPLE_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)       r <= '0;
      else if (load) r <= d[e*SAMPLE_W +: SAMPLE_W];
    end
    assign q[e*SAMPLE_W +: SAMPLE_W] = r;
  end

endmodule

// File: rtl/blk3_fir_lane.sv
// One output lane: tap sum over a window of TAPS samples, oldest first.
module blk3_fir_lane #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned COEF_W   = 16,
  parameter int unsigned TAPS     = 3,
  parameter int unsigned ACC_W    = 34
) (
  input  logic [TAPS*SAMPLE_W-1:0]  win,
  input  logic [TAPS*COEF_W-1:0]    coef,
  output logic signed [ACC_W-1:0]   y
);

  localparam int unsigned PW = SAMPLE_W + COEF_W;

  logic signed [ACC_W-1:0] term [TAPS];

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    logic signed [SAMPLE_W-1:0] s;
    logic signed [COEF_W-1:0]   w;
    logic signed [PW-1:0]       p;
    // tap j multiplies the sample j positions before the newest
    assign s = win[(TAPS-1-j)*SAMPLE_W +: SAMPLE_W];
    assign w = coef[j*COEF_W +: COEF_W];
    assign p = s * w;
    assign term[j] = {{(ACC_W-PW){p[PW-1]}}, p};
  end

  always_comb begin
    y = '0;
    for (int j = 0; j < TAPS; j++) y = y + term[j];
  end

endmodule

// File: rtl/blk3_fir.sv
module blk3_fir
  import blk3_fir_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned COEF_W   = DEF_COEF_W,
  parameter int unsigned LANES    = DEF_LANES,
  parameter int unsigned TAPS     = DEF_TAPS,
  parameter int unsigned ACC_W    = acc_width(DEF_SAMPLE_W, DEF_COEF_W, DEF_TAPS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_vld,
  input  logic [LANES*SAMPLE_W-1:0]  in_blk,
  input  logic [TAPS*COEF_W-1:0]     coef_blk,
  output logic                       out_vld,
  output logic [LANES*ACC_W-1:0]     out_blk
);

  // held samples must fit inside one block
  localparam int unsigned HIST_N = TAPS - 1;
  localparam int unsigned EXT_N  = HIST_N + LANES;

  logic [HIST_N*SAMPLE_W-1:0] hist_q;
  logic [EXT_N*SAMPLE_W-1:0]  ext;

  // entry 0 of hist_q is the oldest sample; lanes follow in time order
  assign ext = {in_blk, hist_q};

  blk3_fir_hist #(
    .SAMPLE_W (SAMPLE_W),
    .DEPTH    (HIST_N)
  ) u_hist (
    .clk  (clk),
    .rst  (rst),
    .load (in_vld),
    .d    (in_blk[LANES*SAMPLE_W-1 -: HIST_N*SAMPLE_W]),
    .q    (hist_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [ACC_W-1:0] y;
    blk3_fir_lane #(
      .SAMPLE_W (SAMPLE_W),
      .COEF_W   (COEF_W),
      .TAPS     (TAPS),
      .ACC_W    (ACC_W)
    ) u_lane (
      .win  (ext[i*SAMPLE_W +: TAPS*SAMPLE_W]),
      .coef (coef_blk),
      .y    (y)
    );
    assign out_blk[i*ACC_W +: ACC_W] = y;
  end

  assign out_vld = in_vld;

endmodule

// File: rtl/blk3_fir_chk.sv
module blk3_fir_chk #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned COEF_W   = 16,
  parameter int unsigned LANES    = 3,
  parameter int unsigned TAPS     = 3,
  parameter int unsigned ACC_W    = 34
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           in_vld,
  input logic [LANES*SAMPLE_W-1:0]      in_blk,
  input logic [TAPS*COEF_W-1:0]         coef_blk,
  input logic [LANES*ACC_W-1:0]         out_blk,
  input logic [(TAPS-1)*SAMPLE_W-1:0]   hist_q
);

  localparam int unsigned HIST_N = TAPS - 1;

  // held samples keep their value through invalid blocks (R7)
  p_hist_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(hist_q));

  // a valid block leaves its newest samples behind (R4)
  p_hist_load_r4: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> hist_q == $past(in_blk[LANES*SAMPLE_W-1 -: HIST_N*SAMPLE_W]));

  // reset clears history (R5)
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;
  always @(posedge clk) begin
    if (rst_d && !rst) begin
      p_reset_clear_r5: assert (hist_q == '0);
    end
  end

  if (LANES == 3 && TAPS == 3) begin : g_lane_props
    longint x0, x1, x2, p1, p2, w0, w1, w2, y0, y1, y2;
    always_comb begin
      x0 = longint'($signed(in_blk[0*SAMPLE_W +: SAMPLE_W]));
      x1 = longint'($signed(in_blk[1*SAMPLE_W +: SAMPLE_W]));
      x2 = longint'($signed(in_blk[2*SAMPLE_W +: SAMPLE_W]));
      p2 = longint'($signed(hist_q[0 +: SAMPLE_W]));
      p1 = longint'($signed(hist_q[SAMPLE_W +: SAMPLE_W]));
      w0 = longint'($signed(coef_blk[0*COEF_W +: COEF_W]));
      w1 = longint'($signed(coef_blk[1*COEF_W +: COEF_W]));
      w2 = longint'($signed(coef_blk[2*COEF_W +: COEF_W]));
      y0 = longint'($signed(out_blk[0*ACC_W +: ACC_W]));
      y1 = longint'($signed(out_blk[1*ACC_W +: ACC_W]));
      y2 = longint'($signed(out_blk[2*ACC_W +: ACC_W]));
    end

    p_lane0_r1: assert property (@(posedge clk) disable iff (rst)
      y0 == w0*x0 + w1*p1 + w2*p2);
    p_lane1_r2: assert property (@(posedge clk) disable iff (rst)
      y1 == w0*x1 + w1*x0 + w2*p1);
    p_lane2_r3: assert property (@(posedge clk) disable iff (rst)
      y2 == w0*x2 + w1*x1 + w2*x0);
  end

endmodule

bind blk3_fir blk3_fir_chk #(
  .SAMPLE_W (SAMPLE_W),
  .COEF_W   (COEF_W),
  .LANES    (LANES),
  .TAPS     (TAPS),
  .ACC_W    (ACC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .in_blk   (in_blk),
  .coef_blk (coef_blk),
  .out_blk  (out_blk),
  .hist_q   (hist_q)
);

// File: tb/test_blk3_fir.sv
module test_blk3_fir;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [47:0]  in_blk = '0;
  logic [47:0]  coef_blk = '0;
  logic         out_vld;
  logic [101:0] out_blk;

  int checks = 0;
  int errors = 0;

  // serial reference state: previous two samples of the stream
  longint rp1 = 0, rp2 = 0;
  longint wa = 0, wb = 0, wc = 0;

  always #2ns clk = ~clk;

  blk3_fir i_blk3_fir (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_blk   (in_blk),
    .coef_blk (coef_blk),
    .out_vld  (out_vld),
    .out_blk  (out_blk)
  );

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic set_coef(input int a, input int b, input int c);
    @(negedge clk);
    wa = a; wb = b; wc = c;
    coef_blk = {16'(c), 16'(b), 16'(a)};
  endtask

  // drive one block, compare lanes against a single-rate filter fed serially
  task automatic run_blk(input bit v, input int x0, input int x1, input int x2, input string tag);
    longint xs [3];
    longint q1, q2, e, g;
    string  lreq [3];
    lreq[0] = "R1"; lreq[1] = "R2"; lreq[2] = "R3";
    xs[0] = x0; xs[1] = x1; xs[2] = x2;
    @(negedge clk);
    in_vld = v;
    in_blk = {16'(x2), 16'(x1), 16'(x0)};
    #1ns;
    q1 = rp1; q2 = rp2;
    for (int i = 0; i < 3; i++) begin
      e  = wa*xs[i] + wb*q1 + wc*q2;
      q2 = q1; q1 = xs[i];
      g  = longint'($signed(out_blk[i*34 +: 34]));
      chk(g == e, $sformatf("%s/%s lane%0d", lreq[i], tag, i), g, e);
    end
    chk(out_vld == v, "R6 out_vld", longint'(out_vld), longint'(v));
    if (v) begin
      rp1 = q1; rp2 = q2;
    end
  endtask

  initial begin
    #(800000ns);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_vld == 1'b0, "R6 reset", longint'(out_vld), 0);
    rst = 1'b0;

    // R5: history starts cleared; zero inputs with unit weights give zero
    set_coef(1, 1, 1);
    run_blk(1, 0, 0, 0, "R5");

    // R4: impulse walks through every tap across two blocks
    set_coef(3, -5, 7);
    run_blk(1, 1, 0, 0, "R4");
    run_blk(1, 0, 0, 0, "R4");
    run_blk(1, 0, 0, 1, "R4");
    run_blk(1, 0, 0, 0, "R4");

    // ramp: every held sample distinct
    set_coef(2, 9, -4);
    for (int k = 0; k < 6; k++) run_blk(1, 3*k+1, 3*k+2, 3*k+3, "ramp");

    // R7: invalid blocks with garbage leave history untouched
    run_blk(0, 12345, -2222, 31000, "R7");
    run_blk(0, -32768, 32767, -1, "R7");
    run_blk(1, 0, 0, 0, "R7");

    // R8: full-scale negative operands
    set_coef(-32768, -32768, -32768);
    run_blk(1, -32768, -32768, -32768, "R8");
    run_blk(1, -32768, -32768, -32768, "R8");
    set_coef(32767, -32768, 32767);
    run_blk(1, 32767, -32768, 32767, "R8");

    // R5: reset mid-stream clears history
    set_coef(1, 1, 1);
    run_blk(1, 500, 600, 700, "R5");
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b0;
    @(negedge clk);
    chk(out_vld == 1'b0, "R6 reset", longint'(out_vld), 0);
    rst = 1'b0;
    rp1 = 0; rp2 = 0;
    run_blk(1, 0, 0, 0, "R5");

    // pseudo-random stream with valid gaps
    set_coef(-1234, 4321, 777);
    for (int k = 0; k < 300; k++) begin
      run_blk(($urandom_range(0, 4) != 0),
              int'($urandom_range(0, 65535)) - 32768,
              int'($urandom_range(0, 65535)) - 32768,
              int'($urandom_range(0, 65535)) - 32768, "rand");
      if (k == 150) set_coef(int'($urandom_range(0, 65535)) - 32768,
                             int'($urandom_range(0, 65535)) - 32768,
                             int'($urandom_range(0, 65535)) - 32768);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule